// File: doc/BRIEF.md
# Dual-Slot Receive Frame Buffer

This block takes an incoming Ethernet payload, one byte at a time, and writes the frame into one of two receive slots as it would look on the wire. Each slot holds a regenerated preamble and start delimiter, then the payload, zero padding up to the minimum payload length, and a CRC32 frame check sequence. Software and hardware pass each slot back and forth through a three-value state register. Software arms a slot by setting it to loaded. The block fills an armed slot, records the stored byte count, and moves the slot to pending. Software reads the slot and then returns it to empty or loaded.

The slot memories are outside the block. The block drives a byte-wide write port that carries a slot select. While any slot is pending, a level interrupt stays high. If no slot is armed when a frame starts, the frame waits at the input until one is armed.

Top module: `rx_dual_slot_buffer`

## Requirements
- R1: After reset, all four slot registers read zero and `rx_irq` is low. Registers are 32 bits and are addressed by word index: 2 is the slot 0 state, 3 the slot 0 count, 4 the slot 1 state, 5 the slot 1 count. A register reads back the full value last written to it. Every other index reads zero, and writes to those indices have no effect.
- R2: A state value of 0 means empty, 1 means loaded and 2 means pending. When a frame starts, slot 0 is taken if its state is loaded. Otherwise slot 1 is taken if its state is loaded.
- R3: If neither slot is loaded, a start byte (`in_valid` and `in_sof` high) sees `in_ready` low and is held, and no buffer write takes place. When a slot becomes loaded, the frame proceeds into that slot.
- R4: The slot image holds 55 55 55 55 55 55 55 D5 at offsets 0 through 7. The payload bytes follow from offset 8, in arrival order.
- R5: A payload shorter than 60 bytes is followed by zero bytes that bring the padded payload to 60 bytes.
- R6: After the padded payload comes the reflected CRC32 (polynomial 0xEDB88320, initial value all ones, output inverted) of the padded payload alone. It is written least significant byte first.
- R7: The slot count becomes the padded length plus 12, and the slot state becomes 2. Both changes are visible after exactly P+4 clock edges following the edge that accepts the last payload byte, where P is the number of padding bytes.
- R8: A payload longer than 2036 bytes (slot size 2048 minus 12) is dropped. That slot's state and count registers keep their values, and no interrupt results.
- R9: `rx_irq` is high exactly while at least one state register holds 2. It follows a software state write on the next edge.
- R10: If a software state write and a frame completion hit the same slot on the same edge, the slot ends up pending with the hardware count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | A payload byte is offered |
| in_sof | input | 1 | The offered byte is the first of a frame |
| in_eof | input | 1 | The offered byte is the last of a frame |
| in_data | input | 8 | Payload byte |
| in_ready | output | 1 | The offered byte is taken on this edge |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register word index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational |
| buf_we | output | 1 | Slot buffer write strobe |
| buf_slot | output | 1 | Slot selected for the write |
| buf_addr | output | 11 | Byte offset within the slot |
| buf_wdata | output | 8 | Byte to write |
| rx_irq | output | 1 | Receive interrupt, level |

## Verification
Buffer writes are combinational from the current phase, so the bench records them on the edge where they occur. After the edge that accepts the last payload byte, the block spends P padding cycles and four check-sequence cycles. The bench therefore counts P+3 edges and confirms the slot is still loaded, then counts one more edge and expects pending, the count and the interrupt together. Register effects show up one edge after the write. A same-edge collision is staged by raising the software write in exactly the cycle of the last check-sequence byte.

// File: rtl/rx_dual_slot_buffer.sv
module rx_dual_slot_buffer #(
  parameter int BUF_BYTES = 2048,
  parameter int MIN_PAY   = 60
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          in_valid,
  input  logic                          in_sof,
  input  logic                          in_eof,
  input  logic [7:0]                    in_data,
  output logic                          in_ready,
  input  logic                          reg_we,
  input  logic [2:0]                    reg_addr,
  input  logic [31:0]                   reg_wdata,
  output logic [31:0]                   reg_rdata,
  output logic                          buf_we,
  output logic                          buf_slot,
  output logic [$clog2(BUF_BYTES)-1:0]  buf_addr,
  output logic [7:0]                    buf_wdata,
  output logic                          rx_irq
);
  localparam int AW      = $clog2(BUF_BYTES);
  localparam int CW      = AW + 1;
  localparam int MAX_PAY = BUF_BYTES - 12;
  localparam logic [31:0] ST_LOADED  = 32'd1;
  localparam logic [31:0] ST_PENDING = 32'd2;

  typedef enum logic [2:0] {S_IDLE, S_PRE, S_PAY, S_PAD, S_FCS} phase_t;

  phase_t      ph;
  logic        cur;
  logic [CW-1:0] pos;
  logic [1:0]  fidx;
  logic [31:0] crc;
  logic        drop;
  logic [31:0] st  [2];
  logic [31:0] cnt [2];

  function automatic logic [31:0] crc_step(input logic [31:0] c, input logic [7:0] d);
    logic [31:0] r;
    r = c ^ {24'd0, d};
    for (int b = 0; b < 8; b++) r = r[0] ? ((r >> 1) ^ 32'hEDB8_8320) : (r >> 1);
    return r;
  endfunction

  logic        can_rx, pick, start, drop_now, done;
  logic [31:0] crc_inv;

  assign can_rx   = (st[0] == ST_LOADED) || (st[1] == ST_LOADED);
  assign pick     = (st[0] == ST_LOADED) ? 1'b0 : 1'b1;
  assign start    = (ph == S_IDLE) && in_valid && in_sof && can_rx;
  assign drop_now = (ph == S_PAY) && in_valid && (drop || pos >= CW'(8 + MAX_PAY));
  assign done     = (ph == S_FCS) && (fidx == 2'd3);
  assign crc_inv  = ~crc;

  assign in_ready  = (ph == S_PAY) || ((ph == S_IDLE) && !in_sof);
  assign buf_slot  = cur;
  assign buf_addr  = pos[AW-1:0];
  assign buf_we    = (ph == S_PRE) || (ph == S_PAD) || (ph == S_FCS) ||
                     ((ph == S_PAY) && in_valid && !drop_now);
  assign rx_irq    = (st[0] == ST_PENDING) || (st[1] == ST_PENDING);

  always_comb begin
    case (ph)
      S_PRE:   buf_wdata = (pos == CW'(7)) ? 8'hD5 : 8'h55;
      S_PAY:   buf_wdata = in_data;
      S_FCS:   buf_wdata = crc_inv[8*fidx +: 8];
      default: buf_wdata = 8'h00;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph   <= S_IDLE;
      cur  <= 1'b0;
      pos  <= '0;
      fidx <= '0;
      crc  <= '1;
      drop <= 1'b0;
    end else begin
      case (ph)
        S_IDLE: if (start) begin
          ph   <= S_PRE;
          cur  <= pick;
          pos  <= '0;
          crc  <= '1;
          drop <= 1'b0;
        end
        S_PRE: begin
          pos <= pos + 1'b1;
          if (pos == CW'(7)) ph <= S_PAY;
        end
        S_PAY: if (in_valid) begin
          if (drop_now) drop <= 1'b1;
          else begin
            pos <= pos + 1'b1;
            crc <= crc_step(crc, in_data);
          end
          if (in_eof) begin
            fidx <= '0;
            if (drop_now)                           ph <= S_IDLE;
            else if (pos + 1'b1 < CW'(8 + MIN_PAY)) ph <= S_PAD;
            else                                    ph <= S_FCS;
          end
        end
        S_PAD: begin
          pos <= pos + 1'b1;
          crc <= crc_step(crc, 8'h00);
          if (pos + 1'b1 == CW'(8 + MIN_PAY)) ph <= S_FCS;
        end
        S_FCS: begin
          pos  <= pos + 1'b1;
          fidx <= fidx + 1'b1;
          if (fidx == 2'd3) ph <= S_IDLE;
        end
        default: ph <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int g = 0; g < 2; g++) begin
        st[g]  <= '0;
        cnt[g] <= '0;
      end
    end else begin
      for (int g = 0; g < 2; g++) begin
        if (done && (cur == 1'(g))) begin
          st[g]  <= ST_PENDING;
          cnt[g] <= 32'(pos + 1'b1);
        end else if (reg_we) begin
          if (reg_addr == 3'(2 + 2*g)) st[g]  <= reg_wdata;
          if (reg_addr == 3'(3 + 2*g)) cnt[g] <= reg_wdata;
        end
      end
    end
  end

  always_comb begin
    case (reg_addr)
      3'd2:    reg_rdata = st[0];
      3'd3:    reg_rdata = cnt[0];
      3'd4:    reg_rdata = st[1];
      3'd5:    reg_rdata = cnt[1];
      default: reg_rdata = '0;
    endcase
  end

  p_pick0_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (start && st[0] == ST_LOADED) |=> (ph == S_PRE && cur == 1'b0));

  p_stall_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (ph == S_IDLE && !can_rx) |=> (ph == S_IDLE));

  p_pre_end_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (ph == S_PRE && pos == CW'(7)) |=> (ph == S_PAY && pos == CW'(8)));

  p_done0_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (done && cur == 1'b0) |=> (st[0] == ST_PENDING));

  p_done1_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (done && cur == 1'b1) |=> (st[1] == ST_PENDING));

  p_drop_keep_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (drop_now && in_eof && !reg_we) |=>
      ($stable(st[0]) && $stable(st[1]) && $stable(cnt[0]) && $stable(cnt[1])));
endmodule

// File: tb/test_rx_dual_slot_buffer.sv
`timescale 1ns/1ps
module test_rx_dual_slot_buffer;
  logic clk = 1'b0, rst_n = 1'b0;
  logic in_valid = 0, in_sof = 0, in_eof = 0;
  logic [7:0] in_data = 0;
  logic in_ready;
  logic reg_we = 0;
  logic [2:0] reg_addr = 0;
  logic [31:0] reg_wdata = 0, reg_rdata;
  logic buf_we, buf_slot, rx_irq;
  logic [10:0] buf_addr;
  logic [7:0] buf_wdata;

  int checks = 0, failures = 0, wr_count = 0;
  logic [7:0] mem [2][2048];

  always #2.5 clk = ~clk;

  rx_dual_slot_buffer i_rx_dual_slot_buffer (
    .clk, .rst_n, .in_valid, .in_sof, .in_eof, .in_data, .in_ready,
    .reg_we, .reg_addr, .reg_wdata, .reg_rdata,
    .buf_we, .buf_slot, .buf_addr, .buf_wdata, .rx_irq);

  always @(posedge clk) if (buf_we) begin
    mem[buf_slot][buf_addr] = buf_wdata;
    wr_count = wr_count + 1;
  end

  // len, seed, slot, expected count
  localparam int VEC [6][4] = '{
    '{1,    8'h11, 0, 72},
    '{59,   8'h22, 1, 72},
    '{60,   8'h33, 0, 72},
    '{61,   8'h44, 1, 73},
    '{100,  8'h55, 1, 112},
    '{2036, 8'h66, 0, 2048}};

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic wr_reg(input int a, input logic [31:0] d);
    @(posedge clk); #1;
    reg_we = 1; reg_addr = 3'(a); reg_wdata = d;
    @(posedge clk); #1;
    reg_we = 0;
  endtask

  task automatic rd_reg(input int a, output logic [31:0] d);
    reg_addr = 3'(a); #0.1; d = reg_rdata;
  endtask

  task automatic clear_mem();
    for (int s = 0; s < 2; s++) for (int i = 0; i < 2048; i++) mem[s][i] = 8'hAA;
  endtask

  task automatic send_frame(input int len, input int seed);
    for (int k = 0; k < len; k++) begin
      in_valid = 1; in_sof = (k == 0); in_eof = (k == len - 1); in_data = 8'(seed + 3*k);
      do @(posedge clk); while (!in_ready);
      #1;
    end
    in_valid = 0; in_sof = 0; in_eof = 0;
  endtask

  function automatic logic [31:0] ref_crc(input logic [31:0] c, input logic [7:0] d);
    logic [31:0] r = c;
    for (int b = 0; b < 8; b++) begin
      logic fb = r[0] ^ d[b];
      r = r >> 1;
      if (fb) r = r ^ 32'hEDB8_8320;
    end
    return r;
  endfunction

  task automatic check_image(input int slot, input int len, input int seed);
    int plen = (len < 60) ? 60 : len;
    logic [31:0] c = '1;
    int bad; logic [7:0] e, fa, fe;
    for (int i = 0; i < plen; i++) c = ref_crc(c, (i < len) ? 8'(seed + 3*i) : 8'h00);
    c = ~c;
    bad = 0; fa = 0; fe = 0;
    for (int i = 0; i < 8 + len; i++) begin
      e = (i < 7) ? 8'h55 : (i == 7) ? 8'hD5 : 8'(seed + 3*(i - 8));
      if (mem[slot][i] != e && bad++ == 0) begin fa = mem[slot][i]; fe = e; end
    end
    chk(bad == 0, "R4 preamble/payload", fa, fe);
    if (plen > len) begin
      bad = 0;
      for (int i = 8 + len; i < 8 + plen; i++)
        if (mem[slot][i] != 8'h00 && bad++ == 0) fa = mem[slot][i];
      chk(bad == 0, "R5 padding", fa, 0);
    end
    bad = 0;
    for (int k = 0; k < 4; k++)
      if (mem[slot][8 + plen + k] != c[8*k +: 8] && bad++ == 0) begin
        fa = mem[slot][8 + plen + k]; fe = c[8*k +: 8];
      end
    chk(bad == 0, "R6 fcs", fa, fe);
  endtask

  // sends a frame to an armed slot and checks timing, registers and image
  task automatic run_frame(input int slot, input int len, input int seed, input int exp_cnt);
    int pad = (len < 60) ? 60 - len : 0;
    logic [31:0] v;
    clear_mem();
    send_frame(len, seed);
    repeat (pad + 3) @(posedge clk);
    @(negedge clk);
    rd_reg(2 + 2*slot, v);
    chk(v == 1, "R7 state before due edge", v, 1);
    @(posedge clk); @(negedge clk);
    rd_reg(2 + 2*slot, v);
    chk(v == 2, "R7 state pending", v, 2);
    rd_reg(3 + 2*slot, v);
    chk(v == 32'(exp_cnt), "R7 count", v, exp_cnt);
    chk(rx_irq == 1, "R9 irq with pending", rx_irq, 1);
    check_image(slot, len, seed);
  endtask

  initial begin
    #750000;
    failures++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [31:0] v;
    int w0;
    repeat (3) @(posedge clk); #1 rst_n = 1;
    @(negedge clk);
    // R1 reset
    for (int a = 2; a < 6; a++) begin rd_reg(a, v); chk(v == 0, "R1 reset reg", v, 0); end
    chk(rx_irq == 0, "R1 reset irq", rx_irq, 0);
    // R1 unmapped indices
    wr_reg(0, 32'hFFFF_FFFF); wr_reg(1, 32'hFFFF_FFFF); wr_reg(6, 32'hFFFF_FFFF); wr_reg(7, 32'hFFFF_FFFF);
    @(negedge clk);
    for (int a = 0; a < 8; a++) begin rd_reg(a, v); chk(v == 0, "R1 unmapped/no effect", v, 0); end
    wr_reg(3, 32'h1234_5678); @(negedge clk); rd_reg(3, v);
    chk(v == 32'h1234_5678, "R1 readback", v, 32'h1234_5678);
    wr_reg(3, 0);

    // table walk
    for (int n = 0; n < 6; n++) begin
      wr_reg(2 + 2*VEC[n][2], 1);
      run_frame(VEC[n][2], VEC[n][0], VEC[n][1], VEC[n][3]);
      wr_reg(2 + 2*VEC[n][2], 0);
      @(negedge clk);
      chk(rx_irq == 0, "R9 irq after clear", rx_irq, 0);
    end

    // R3 stall with no slot loaded
    w0 = wr_count;
    in_valid = 1; in_sof = 1; in_eof = 0; in_data = 8'h01;
    for (int k = 0; k < 20; k++) begin
      @(negedge clk);
      if (in_ready) begin chk(0, "R3 in_ready while stalled", 1, 0); break; end
    end
    chk(wr_count == w0, "R3 no writes while stalled", wr_count - w0, 0);
    wr_reg(4, 1);
    run_frame(1, 70, 8'h01, 82);
    wr_reg(4, 0);

    // R2 both loaded: slot 0 first, then slot 1
    wr_reg(2, 1); wr_reg(4, 1);
    run_frame(0, 64, 8'h90, 76);
    @(negedge clk); rd_reg(4, v);
    chk(v == 1, "R2 slot 1 untouched", v, 1);
    run_frame(1, 65, 8'hA0, 77);
    wr_reg(2, 0); @(negedge clk);
    chk(rx_irq == 1, "R9 irq held by other slot", rx_irq, 1);
    wr_reg(4, 0); @(negedge clk);
    chk(rx_irq == 0, "R9 irq low all clear", rx_irq, 0);

    // R8 oversize frame dropped
    wr_reg(3, 32'h123); wr_reg(2, 1);
    send_frame(2037, 8'h07);
    repeat (8) @(posedge clk);
    @(negedge clk);
    rd_reg(2, v); chk(v == 1, "R8 state kept", v, 1);
    rd_reg(3, v); chk(v == 32'h123, "R8 count kept", v, 32'h123);
    chk(rx_irq == 0, "R8 no irq", rx_irq, 0);
    run_frame(0, 64, 8'h3C, 76);

    // R10 same-edge collision
    wr_reg(2, 1);
    send_frame(64, 8'h5A);
    repeat (3) @(posedge clk);
    #1 reg_we = 1; reg_addr = 3'd2; reg_wdata = 0;
    @(posedge clk); #1 reg_we = 0;
    @(negedge clk);
    rd_reg(2, v); chk(v == 2, "R10 hardware wins state", v, 2);
    rd_reg(3, v); chk(v == 76, "R10 hardware count", v, 76);
    wr_reg(2, 0); @(negedge clk);
    rd_reg(2, v); chk(v == 0, "R10 later write applies", v, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule